// File: doc/BRIEF.md
# Dual-Buffer SPI Write Front End

This block receives buffer-load commands over a SPI slave link (mode 0, most significant bit first). It fills one of two on-chip page buffers with the incoming data. The SPI pins are brought into the system clock domain through synchronisers and are oversampled there. A transaction is framed by chip select going low. It carries one opcode byte, then three address bytes, then any number of data bytes.

The opcode picks the target buffer. The low bits of the 24-bit address field give the starting byte index. Each data byte that follows lands at the next index. The index wraps back to zero past the last byte of the page, and loading goes on until chip select rises. A mode input selects between a 512-byte page and a 528-byte page.

When chip select rises after an accepted command, a one-cycle strobe hands the opcode and the address field to a downstream program sequencer. That sequencer reads the buffers through a separate combinational read port.

Top module: `dbuf_spi_front`

## Requirements
- R1: Opcode 44h directs the command's data to buffer 0 and opcode 47h directs it to buffer 1, in either page mode.
- R2: The three bytes after the opcode form a 24-bit address field, most significant byte first. With `std_mode`=0 (512-byte page), the starting index is field bits [8:0] and all higher bits are ignored.
- R3: With `std_mode`=1 (528-byte page), the starting index is field bits [9:0]. A value of 528 or more has 528 subtracted from it.
- R4: Each complete data byte, received most significant bit first, is written at the current index, and the index then advances by one. Consecutive bytes of one command land at consecutive indices.
- R5: After index 511 (512-byte mode) or index 527 (528-byte mode), the next data byte is written at index 0, and loading continues for as long as bytes arrive.
- R6: A data byte that has fewer than 8 bits when chip select rises is discarded and writes nothing.
- R7: A transaction whose opcode is neither 44h nor 47h writes nothing and raises no strobe until chip select has gone high again.
- R8: If `busy` is high when the opcode byte completes, the whole transaction is ignored: no writes and no strobe.
- R9: A few cycles after chip select rises on an accepted command whose three address bytes were all received, `cmd_done` pulses high for exactly one cycle. While it is high, `cmd_opcode` and `cmd_addr` carry that command's opcode and 24-bit field.
- R10: `rd_data` equals byte `rd_idx` of the buffer chosen by `rd_sel` (0 or 1) in the same cycle. After reset every buffer byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, sampled on its rising edge |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| std_mode | input | 1 | 0: 512-byte page, 1: 528-byte page |
| busy | input | 1 | When high at opcode completion, the command is ignored |
| rd_sel | input | 1 | Buffer chosen for the read port |
| rd_idx | input | 10 | Byte index for the read port |
| rd_data | output | 8 | Byte read from the chosen buffer |
| cmd_done | output | 1 | One-cycle command-complete strobe |
| cmd_opcode | output | 8 | Opcode of the completed command |
| cmd_addr | output | 24 | Address field of the completed command |

## Verification
The bound checker watches every write on every cycle. It confirms that the write index stays inside the active page and that each write is one step past the previous one, with the wrap. It also confirms that no write occurs in a transaction whose opcode was not accepted, and that the strobe lasts one cycle and follows a chip-select rise. The bench scenarios cover the rest: buffer choice, masking of the don't-care address bits, the reduction of large addresses in 528-byte mode, the discarding of partial bytes, the suppression of commands under `busy` or a wrong opcode, and the strobe contents. These show up only as buffer contents seen through the read port.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  parameter int BYTE_W    = 8;
  parameter int ADDR_W    = 24;
  parameter int BIN_BYTES = 512;
  parameter int STD_BYTES = 528;
  localparam int IDX_W    = $clog2(STD_BYTES);
  localparam int BIN_W    = $clog2(BIN_BYTES);

  localparam logic [BYTE_W-1:0] OPC_LOAD0 = 8'h44;
  localparam logic [BYTE_W-1:0] OPC_LOAD1 = 8'h47;

  typedef logic [IDX_W-1:0] idx_t;
  typedef enum logic [1:0] {ST_OPC, ST_ADDR, ST_DATA, ST_SKIP} cmd_st_e;

  function automatic idx_t last_idx(input logic std_mode);
    return std_mode ? idx_t'(STD_BYTES - 1) : idx_t'(BIN_BYTES - 1);
  endfunction

  // starting index from the 24-bit field
  function automatic idx_t start_idx(input logic [ADDR_W-1:0] fld, input logic std_mode);
    idx_t raw;
    raw = fld[IDX_W-1:0];
    if (!std_mode) return idx_t'(fld[BIN_W-1:0]);
    if (raw >= idx_t'(STD_BYTES)) return raw - idx_t'(STD_BYTES);
    return raw;
  endfunction

  function automatic idx_t next_idx(input idx_t cur, input logic std_mode);
    return (cur == last_idx(std_mode)) ? '0 : cur + idx_t'(1);
  endfunction
endpackage

// File: rtl/dbuf_spi_rx.sv
module dbuf_spi_rx
  import dbuf_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val,
  output logic              cs_act,
  output logic              cs_rise
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC-1:0]   sclk_q, cs_q, mosi_q;
  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic              sclk_s, mosi_s, cs_s, sclk_rise;

  assign sclk_s    = sclk_q[SYNC-1];
  assign mosi_s    = mosi_q[SYNC-1];
  assign cs_s      = cs_q[SYNC-1];
  assign cs_act    = !cs_s;
  assign cs_rise   = cs_s && !cs_d;
  assign sclk_rise = sclk_s && !sclk_d && cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC-2:0], sclk};
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg   <= {shreg[BYTE_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          byte_vld <= 1'b1;
          byte_val <= {shreg, mosi_s};
        end
      end
    end
  end
endmodule

// File: rtl/dbuf_cmd_ctrl.sv
module dbuf_cmd_ctrl
  import dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_mode,
  input  logic              busy,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              cs_act,
  input  logic              cs_rise,
  output logic              opc_accept,
  output logic              wr_en,
  output logic              wr_sel,
  output idx_t              wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              cmd_done,
  output logic [BYTE_W-1:0] cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int NADDR = ADDR_W / BYTE_W;

  cmd_st_e           st;
  logic [1:0]        addr_cnt;
  logic [BYTE_W-1:0] opc;
  logic [ADDR_W-1:0] addr_sh;
  logic [ADDR_W-1:0] addr_nx;
  idx_t              ptr;
  logic              sel;

  assign addr_nx    = {addr_sh[ADDR_W-BYTE_W-1:0], byte_val};
  assign opc_accept = (st == ST_OPC) && byte_vld && cs_act && !busy &&
                      (byte_val == OPC_LOAD0 || byte_val == OPC_LOAD1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; addr_cnt <= '0; opc <= '0; addr_sh <= '0; ptr <= '0; sel <= 1'b0;
      wr_en <= 1'b0; wr_sel <= 1'b0; wr_idx <= '0; wr_data <= '0;
      cmd_done <= 1'b0; cmd_opcode <= '0; cmd_addr <= '0;
    end else begin
      wr_en    <= 1'b0;
      cmd_done <= 1'b0;
      if (cs_rise) begin
        if (st == ST_DATA) begin
          cmd_done   <= 1'b1;
          cmd_opcode <= opc;
          cmd_addr   <= addr_sh;
        end
        st <= ST_OPC;
      end else if (!cs_act) begin
        st <= ST_OPC;
      end else if (byte_vld) begin
        unique case (st)
          ST_OPC: begin
            if (opc_accept) begin
              opc      <= byte_val;
              sel      <= (byte_val == OPC_LOAD1);
              addr_cnt <= '0;
              st       <= ST_ADDR;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            addr_sh  <= addr_nx;
            addr_cnt <= addr_cnt + 2'd1;
            if (addr_cnt == 2'(NADDR - 1)) begin
              ptr <= start_idx(addr_nx, std_mode);
              st  <= ST_DATA;
            end
          end
          ST_DATA: begin
            wr_en   <= 1'b1;
            wr_sel  <= sel;
            wr_idx  <= ptr;
            wr_data <= byte_val;
            ptr     <= next_idx(ptr, std_mode);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbuf_page_buf.sv
module dbuf_page_buf
  import dbuf_pkg::*;
#(
  parameter int DEPTH = STD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  idx_t              widx,
  input  logic [BYTE_W-1:0] wdata,
  input  idx_t              ridx,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && widx < idx_t'(DEPTH)) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = (ridx < idx_t'(DEPTH)) ? mem[ridx] : '0;
endmodule

// File: rtl/dbuf_spi_front.sv
module dbuf_spi_front
  import dbuf_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              std_mode,
  input  logic              busy,
  input  logic              rd_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic              cmd_done,
  output logic [BYTE_W-1:0] cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int NBUF = 2;

  logic              byte_vld, cs_act, cs_rise, opc_accept;
  logic [BYTE_W-1:0] byte_val, wr_data;
  logic              wr_en, wr_sel;
  idx_t              wr_idx;
  logic [BYTE_W-1:0] buf_rd [NBUF];

  dbuf_spi_rx #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .byte_vld(byte_vld), .byte_val(byte_val), .cs_act(cs_act), .cs_rise(cs_rise)
  );

  dbuf_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .std_mode(std_mode), .busy(busy),
    .byte_vld(byte_vld), .byte_val(byte_val), .cs_act(cs_act), .cs_rise(cs_rise),
    .opc_accept(opc_accept), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .cmd_done(cmd_done), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    dbuf_page_buf #(.DEPTH(STD_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (wr_sel == 1'(g))), .widx(wr_idx), .wdata(wr_data),
      .ridx(rd_idx), .rdata(buf_rd[g])
    );
  end

  assign rd_data = rd_sel ? buf_rd[1] : buf_rd[0];
endmodule

// File: rtl/dbuf_spi_front_chk.sv
module dbuf_spi_front_chk
  import dbuf_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic std_mode,
  input logic cs_act,
  input logic cs_rise,
  input logic opc_accept,
  input logic wr_en,
  input idx_t wr_idx,
  input logic cmd_done
);
  idx_t prev_idx;
  logic have_prev, accepted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_idx <= '0; have_prev <= 1'b0; accepted <= 1'b0;
    end else begin
      if (!cs_act) begin
        have_prev <= 1'b0;
        accepted  <= 1'b0;
      end else begin
        if (wr_en) begin
          have_prev <= 1'b1;
          prev_idx  <= wr_idx;
        end
        if (opc_accept) accepted <= 1'b1;
      end
    end
  end

  a_r4_idx_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < (std_mode ? STD_BYTES : BIN_BYTES)));

  a_r5_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && have_prev) |->
      (wr_idx == ((int'(prev_idx) == (std_mode ? STD_BYTES : BIN_BYTES) - 1) ? idx_t'(0) : prev_idx + idx_t'(1))));

  a_r7_write_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> accepted);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  a_r9_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(cs_rise));
endmodule

bind dbuf_spi_front dbuf_spi_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .std_mode(std_mode), .cs_act(cs_act), .cs_rise(cs_rise),
  .opc_accept(opc_accept), .wr_en(wr_en), .wr_idx(wr_idx), .cmd_done(cmd_done)
);

// File: tb/dbuf_spi_front_bench.sv
module dbuf_spi_front_bench;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0, std_mode = 0, busy = 0, rd_sel = 0;
  logic [9:0]  rd_idx = 0;
  logic [7:0]  rd_data, cmd_opcode;
  logic        cmd_done;
  logic [23:0] cmd_addr;

  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;
  logic [7:0]  last_opc;
  logic [23:0] last_addr;
  logic [7:0]  model [2][528];

  always #4 clk = ~clk;

  dbuf_spi_front u_dbuf_spi_front (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .std_mode(std_mode), .busy(busy), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .cmd_done(cmd_done), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr)
  );

  always @(negedge clk) if (rst_n && cmd_done) begin
    done_cnt++;
    last_opc  = cmd_opcode;
    last_addr = cmd_addr;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      repeat (4) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
  endtask

  function automatic int page_start(input logic [23:0] a, input bit sm);
    if (sm) return int'(a[9:0]) % 528;
    return int'(a[8:0]);
  endfunction

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed + 8'(k * 29);
  endfunction

  // full transaction; partial = extra bits sent before cs rises
  task automatic run_cmd(input logic [7:0] opc, input logic [23:0] a, input int n,
                         input logic [7:0] seed, input int partial, input bit accept);
    int size, idx, d0;
    size = std_mode ? 528 : 512;
    d0 = done_cnt;
    cs_n = 0;
    repeat (4) @(negedge clk);
    send_bits(opc, 8);
    send_bits(a[23:16], 8);
    send_bits(a[15:8], 8);
    send_bits(a[7:0], 8);
    for (int k = 0; k < n; k++) send_bits(dbyte(seed, k), 8);
    if (partial > 0) send_bits(8'hFF, partial);
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (12) @(negedge clk);
    if (accept) begin
      idx = page_start(a, std_mode);
      for (int k = 0; k < n; k++) begin
        model[opc == 8'h47 ? 1 : 0][idx] = dbyte(seed, k);
        idx = (idx + 1) % size;
      end
    end
    check("R9 strobe count", done_cnt - d0, accept ? 1 : 0);
    if (accept) begin
      check("R9 strobe opcode", last_opc, opc);
      check("R9 strobe addr", last_addr, a);
    end
  endtask

  task automatic read_chk(input string req, input bit sel, input int idx);
    @(negedge clk);
    rd_sel = sel;
    rd_idx = 10'(idx);
    @(negedge clk);
    check(req, rd_data, model[sel][idx]);
  endtask

  task automatic t_reset;
    check("R9 no strobe at reset", cmd_done, 0);
    read_chk("R10 reset buf0[0]", 0, 0);
    read_chk("R10 reset buf1[527]", 1, 527);
    read_chk("R10 reset buf0[300]", 0, 300);
  endtask

  task automatic t_basic;
    std_mode = 0;
    run_cmd(8'h44, 24'h000010, 4, 8'h11, 0, 1);
    for (int i = 15; i < 21; i++) read_chk("R1 R4 buf0 run", 0, i);
    read_chk("R1 buf1 untouched", 1, 16);
  endtask

  task automatic t_wrap512;
    std_mode = 0;
    run_cmd(8'h47, 24'hABCDFE, 5, 8'h5A, 0, 1);
    read_chk("R2 R5 buf1[510]", 1, 510);
    read_chk("R5 buf1[511]", 1, 511);
    read_chk("R5 buf1[0]", 1, 0);
    read_chk("R5 buf1[2]", 1, 2);
    read_chk("R5 buf1[3]", 1, 3);
    read_chk("R1 buf0[510]", 0, 510);
    read_chk("R2 buf1[512] not used", 1, 512);
  endtask

  task automatic t_wrap528;
    std_mode = 1;
    run_cmd(8'h44, 24'h00020E, 4, 8'hC3, 0, 1);
    read_chk("R3 R5 buf0[526]", 0, 526);
    read_chk("R5 buf0[527]", 0, 527);
    read_chk("R5 buf0[0]", 0, 0);
    read_chk("R5 buf0[1]", 0, 1);
    run_cmd(8'h47, 24'hF003FF, 2, 8'h77, 0, 1);
    read_chk("R3 reduced buf1[495]", 1, 495);
    read_chk("R3 reduced buf1[496]", 1, 496);
    std_mode = 0;
  endtask

  task automatic t_partial;
    run_cmd(8'h47, 24'h000064, 2, 8'h90, 5, 1);
    read_chk("R6 buf1[100]", 1, 100);
    read_chk("R6 buf1[101]", 1, 101);
    read_chk("R6 partial byte dropped buf1[102]", 1, 102);
  endtask

  task automatic t_bad_opcode;
    run_cmd(8'h45, 24'h000020, 3, 8'hAA, 0, 0);
    read_chk("R7 buf0[32] unchanged", 0, 32);
    read_chk("R7 buf1[32] unchanged", 1, 32);
    run_cmd(8'h44, 24'h000020, 1, 8'h3C, 0, 1);
    read_chk("R7 next command works", 0, 32);
  endtask

  task automatic t_busy;
    busy = 1;
    run_cmd(8'h44, 24'h000040, 3, 8'hE1, 0, 0);
    busy = 0;
    read_chk("R8 buf0[64] unchanged", 0, 64);
    read_chk("R8 buf0[65] unchanged", 0, 65);
  endtask

  task automatic t_no_data;
    run_cmd(8'h47, 24'h123456, 0, 8'h00, 0, 1);
    read_chk("R9 no data no write", 1, 86);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) for (int i = 0; i < 528; i++) model[s][i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_basic;
    t_wrap512;
    t_wrap528;
    t_partial;
    t_bad_opcode;
    t_busy;
    t_no_data;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule